// File: doc/BRIEF.md
# Banked RAM Address Translator

This block sits between a 16-bit CPU address bus and a 128 KB static RAM built as four 32 KB banks. It turns each CPU address into a 17-bit RAM address. The low 32 KB of the CPU space always reaches bank 0, and the high 32 KB reaches the bank held in a two-bit bank register. The RAM strobes (chip, write and output enable) pass straight through, so read and write timing are the same as for a plain RAM.

An optional zero-page swap gives each bank its own private scratch bytes. When the swap is on, the upper half of page zero (CPU 0x0080..0x00FF) is served from offset 0x0080..0x00FF of the selected bank. The high window at CPU 0x8080..0x80FF, which would normally reach those bytes, is redirected to bank 0, so it shows the same contents whichever bank is selected. Code can therefore switch banks and still keep jump vectors in a shared place.

A small control register holds the bank number and the swap mode. It is a two-state machine. The states are FLAT (swap off) and ZPSWAP (swap on). Transition ENABLE_SWAP goes from FLAT to ZPSWAP on a control write with the active-low swap input low. Transition DISABLE_SWAP goes from ZPSWAP to FLAT on a control write with that input high. Any other control write keeps the current state and only reloads the bank. Address mapping is purely combinational from the registered values.

Top module: `bank_xlate`

## Requirements
- R1: ram_addr[14:0] always equals cpu_addr[14:0]. Only ram_addr[16:15], the bank field, is chosen by the mapping.
- R2: Outside the swapped window, CPU addresses with bit 15 clear reach bank 0 (bank field 2'b00). This covers 0x0000..0x7FFF with the swap off, and 0x0000..0x007F and 0x0100..0x7FFF with the swap on.
- R3: With the swap off, CPU addresses 0x8000..0xFFFF reach the registered bank. Bank 0 mirrors the low half, and bank 1 gives a flat 64 KB space.
- R4: With the swap on, CPU addresses 0x0080..0x00FF reach offset 0x0080..0x00FF of the registered bank.
- R5: With the swap on, CPU addresses 0x8080..0x80FF reach offset 0x0080..0x00FF of bank 0, for every bank value.
- R6: With the swap on, CPU addresses 0x8000..0x807F and 0x8100..0xFFFF reach the registered bank.
- R7: On a rising clock edge with cfg_we high, the register loads cfg_bank. The swap turns on if cfg_zp_n is low and off if it is high. The new mapping applies from that edge onwards.
- R8: While cfg_we is low, changes on cfg_bank and cfg_zp_n leave the mapping unchanged.
- R9: A synchronous reset clears the bank to 0 and turns the swap off. High addresses then mirror the low 32 KB.
- R10: ram_ce_n, ram_we_n and ram_oe_n equal cpu_ce_n, cpu_we_n and cpu_oe_n in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the control register |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Control write strobe |
| cfg_bank | input | 2 | Bank number to load |
| cfg_zp_n | input | 1 | Zero-page swap request, active low |
| cpu_addr | input | 16 | CPU address |
| cpu_ce_n | input | 1 | CPU chip enable, active low |
| cpu_we_n | input | 1 | CPU write enable, active low |
| cpu_oe_n | input | 1 | CPU output enable, active low |
| ram_addr | output | 17 | Physical RAM address {bank, offset} |
| ram_ce_n | output | 1 | RAM chip enable, active low |
| ram_we_n | output | 1 | RAM write enable, active low |
| ram_oe_n | output | 1 | RAM output enable, active low |

## Verification
An address or strobe change shows up on the RAM side in the same cycle, with no register in the path. A control write takes effect from the first rising edge that samples cfg_we high. The bench drives every input 1 ns after a rising edge and compares the outputs at the next falling edge. That way each address check sees the settled combinational result, and the check after a control write sees the value the register loaded at the edge before. Expected items go into a queue in the same cycle as the drive, and the monitor pops exactly one item per falling edge.

// File: rtl/bxl_pkg.sv
`timescale 1ns/1ps
package bxl_pkg;

    // Where a CPU access lands
    typedef enum logic [1:0] {
        RGN_BASE      = 2'd0,   // low half, always bank 0
        RGN_BANKED    = 2'd1,   // high half, selected bank
        RGN_ZP_PRIV   = 2'd2,   // swapped page-zero window, selected bank
        RGN_ZP_SHARED = 2'd3    // swapped high window, always bank 0
    } region_e;

    // Control register state
    typedef enum logic {
        MODE_FLAT   = 1'b0,
        MODE_ZPSWAP = 1'b1
    } zp_mode_e;

endpackage

// File: rtl/bxl_ctrl_reg.sv
`timescale 1ns/1ps
module bxl_ctrl_reg
    import bxl_pkg::*;
#(
    parameter int BANK_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [BANK_W-1:0] wr_bank,
    input  logic              wr_zp_n,
    output logic [BANK_W-1:0] bank_q,
    output logic              zp_on
);

    zp_mode_e state_q, state_d;

    // next state: ENABLE_SWAP / DISABLE_SWAP
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MODE_FLAT:   if (wr_en && !wr_zp_n) state_d = MODE_ZPSWAP;
            MODE_ZPSWAP: if (wr_en &&  wr_zp_n) state_d = MODE_FLAT;
            default:     state_d = MODE_FLAT;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= MODE_FLAT;
            bank_q  <= '0;
        end else begin
            state_q <= state_d;
            if (wr_en) bank_q <= wr_bank;
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            MODE_FLAT:   zp_on = 1'b0;
            MODE_ZPSWAP: zp_on = 1'b1;
            default:     zp_on = 1'b0;
        endcase
    end

    AST_CFG_LOAD: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (bank_q == $past(wr_bank)) && (zp_on == !$past(wr_zp_n))); // R7
    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(bank_q) && $stable(zp_on)); // R8
    AST_RST_STATE: assert property (@(posedge clk)
        rst |=> (bank_q == '0) && !zp_on); // R9

endmodule

// File: rtl/bxl_region_dec.sv
`timescale 1ns/1ps
module bxl_region_dec
    import bxl_pkg::*;
#(
    parameter int CPU_AW  = 16,
    parameter int WIN_LSB = 7
) (
    input  logic [CPU_AW-1:0] addr,
    input  logic              zp_on,
    output region_e           region
);

    localparam int OFF_W   = CPU_AW - 1;
    localparam int TAG_W   = OFF_W - WIN_LSB;
    localparam logic [TAG_W-1:0] WIN_TAG = TAG_W'(1);

    logic in_win;
    logic hi_half;

    assign in_win  = (addr[OFF_W-1:WIN_LSB] == WIN_TAG);
    assign hi_half = addr[CPU_AW-1];

    always_comb begin
        unique case ({zp_on && in_win, hi_half})
            2'b00:   region = RGN_BASE;
            2'b01:   region = RGN_BANKED;
            2'b10:   region = RGN_ZP_PRIV;
            2'b11:   region = RGN_ZP_SHARED;
            default: region = RGN_BASE;
        endcase
    end

endmodule

// File: rtl/bxl_addr_map.sv
`timescale 1ns/1ps
module bxl_addr_map
    import bxl_pkg::*;
#(
    parameter int OFF_W  = 15,
    parameter int BANK_W = 2
) (
    input  region_e                  region,
    input  logic [BANK_W-1:0]        bank,
    input  logic [OFF_W-1:0]         offset,
    output logic [BANK_W+OFF_W-1:0]  phys
);

    logic [BANK_W-1:0] sel;

    always_comb begin
        unique case (region)
            RGN_BASE, RGN_ZP_SHARED: sel = '0;
            RGN_BANKED, RGN_ZP_PRIV: sel = bank;
            default:                 sel = '0;
        endcase
    end

    assign phys = {sel, offset};

endmodule

// File: rtl/bank_xlate.sv
`timescale 1ns/1ps
module bank_xlate
    import bxl_pkg::*;
#(
    parameter int CPU_AW  = 16,
    parameter int BANK_W  = 2,
    parameter int WIN_LSB = 7
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         cfg_we,
    input  logic [BANK_W-1:0]            cfg_bank,
    input  logic                         cfg_zp_n,
    input  logic [CPU_AW-1:0]            cpu_addr,
    input  logic                         cpu_ce_n,
    input  logic                         cpu_we_n,
    input  logic                         cpu_oe_n,
    output logic [BANK_W+CPU_AW-2:0]     ram_addr,
    output logic                         ram_ce_n,
    output logic                         ram_we_n,
    output logic                         ram_oe_n
);

    localparam int OFF_W  = CPU_AW - 1;
    localparam int RAM_AW = BANK_W + OFF_W;
    localparam int TAG_W  = OFF_W - WIN_LSB;
    localparam logic [TAG_W-1:0] WIN_TAG = TAG_W'(1);

    logic [BANK_W-1:0] bank_q;
    logic              zp_on;
    region_e           region;

    bxl_ctrl_reg #(.BANK_W(BANK_W)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (cfg_we),
        .wr_bank (cfg_bank),
        .wr_zp_n (cfg_zp_n),
        .bank_q  (bank_q),
        .zp_on   (zp_on)
    );

    bxl_region_dec #(.CPU_AW(CPU_AW), .WIN_LSB(WIN_LSB)) u_dec (
        .addr   (cpu_addr),
        .zp_on  (zp_on),
        .region (region)
    );

    bxl_addr_map #(.OFF_W(OFF_W), .BANK_W(BANK_W)) u_map (
        .region (region),
        .bank   (bank_q),
        .offset (cpu_addr[OFF_W-1:0]),
        .phys   (ram_addr)
    );

    assign ram_ce_n = cpu_ce_n;
    assign ram_we_n = cpu_we_n;
    assign ram_oe_n = cpu_oe_n;

    // checks on the mapping, relating ports to the control state
    logic win_hit;
    assign win_hit = (cpu_addr[OFF_W-1:WIN_LSB] == WIN_TAG);

    AST_OFFSET_KEEP: assert property (@(posedge clk) disable iff (rst)
        ram_addr[OFF_W-1:0] == cpu_addr[OFF_W-1:0]); // R1
    AST_LOW_FIXED: assert property (@(posedge clk) disable iff (rst)
        (!cpu_addr[CPU_AW-1] && !(zp_on && win_hit)) |-> (ram_addr[RAM_AW-1:OFF_W] == '0)); // R2
    AST_HIGH_FLAT: assert property (@(posedge clk) disable iff (rst)
        (!zp_on && cpu_addr[CPU_AW-1]) |-> (ram_addr[RAM_AW-1:OFF_W] == bank_q)); // R3
    AST_ZP_PRIV: assert property (@(posedge clk) disable iff (rst)
        (zp_on && win_hit && !cpu_addr[CPU_AW-1]) |-> (ram_addr[RAM_AW-1:OFF_W] == bank_q)); // R4
    AST_ZP_SHARED: assert property (@(posedge clk) disable iff (rst)
        (zp_on && win_hit && cpu_addr[CPU_AW-1]) |-> (ram_addr[RAM_AW-1:OFF_W] == '0)); // R5
    AST_HIGH_SWAP: assert property (@(posedge clk) disable iff (rst)
        (zp_on && !win_hit && cpu_addr[CPU_AW-1]) |-> (ram_addr[RAM_AW-1:OFF_W] == bank_q)); // R6

endmodule

// File: tb/tb_bank_xlate.sv
`timescale 1ns/1ps
module tb_bank_xlate;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_bank = 2'd0;
    logic        cfg_zp_n = 1'b1;
    logic [15:0] cpu_addr = 16'h0000;
    logic        cpu_ce_n = 1'b1;
    logic        cpu_we_n = 1'b1;
    logic        cpu_oe_n = 1'b1;
    logic [16:0] ram_addr;
    logic        ram_ce_n, ram_we_n, ram_oe_n;

    always #2 clk = ~clk;   // 250 MHz

    bank_xlate dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_bank(cfg_bank), .cfg_zp_n(cfg_zp_n),
        .cpu_addr(cpu_addr), .cpu_ce_n(cpu_ce_n), .cpu_we_n(cpu_we_n), .cpu_oe_n(cpu_oe_n),
        .ram_addr(ram_addr), .ram_ce_n(ram_ce_n), .ram_we_n(ram_we_n), .ram_oe_n(ram_oe_n)
    );

    typedef struct {
        logic [15:0] addr;
        logic [16:0] exp_addr;
        logic [2:0]  exp_strb;
        string       req;
    } sb_item_t;

    sb_item_t sb[$];
    int  n_run  = 0;
    int  n_fail = 0;
    bit  done   = 0;

    // bench model of the control register
    logic [1:0] mdl_bank = 2'd0;
    bit         mdl_zp   = 0;

    function automatic logic [16:0] ref_map(logic [15:0] a, logic [1:0] b, bit zp);
        logic swapped_win;
        logic [1:0] bk;
        swapped_win = zp && (a[14:7] == 8'h01);
        if (swapped_win) bk = a[15] ? 2'd0 : b;
        else             bk = a[15] ? b : 2'd0;
        return {bk, a[14:0]};
    endfunction

    function automatic string req_of(logic [15:0] a, bit zp);
        bit w;
        w = (a[14:7] == 8'h01);
        if (!a[15] && !(zp && w)) return "R2";
        if (!zp)                  return "R3";
        if (w && !a[15])          return "R4";
        if (w)                    return "R5";
        return "R6";
    endfunction

    task automatic expect_map(input logic [15:0] a, input string rq);
        sb_item_t it;
        @(posedge clk); #1;
        cpu_addr = a;
        it.addr = a;
        it.exp_addr = ref_map(a, mdl_bank, mdl_zp);
        it.exp_strb = {cpu_ce_n, cpu_we_n, cpu_oe_n};
        it.req = rq;
        sb.push_back(it);
    endtask

    task automatic cfg_write(input logic [1:0] b, input bit zp);
        @(posedge clk); #1;
        cfg_we = 1'b1; cfg_bank = b; cfg_zp_n = !zp;
        @(posedge clk); #1;
        cfg_we = 1'b0;
        mdl_bank = b; mdl_zp = zp;
    endtask

    // monitor: one item per falling edge
    initial begin
        forever begin
            @(negedge clk);
            if (sb.size() != 0) begin
                sb_item_t it;
                it = sb.pop_front();
                n_run++;
                if (ram_addr !== it.exp_addr) begin
                    n_fail++;
                    $display("FAIL %s addr=%h actual=%h expected=%h", it.req, it.addr, ram_addr, it.exp_addr);
                end
                if (ram_addr[14:0] !== it.addr[14:0]) begin
                    n_run++; n_fail++;
                    $display("FAIL R1 offset actual=%h expected=%h", ram_addr[14:0], it.addr[14:0]);
                end
                n_run++;
                if ({ram_ce_n, ram_we_n, ram_oe_n} !== it.exp_strb) begin
                    n_fail++;
                    $display("FAIL R10 strobes actual=%b expected=%b", {ram_ce_n, ram_we_n, ram_oe_n}, it.exp_strb);
                end
            end
        end
    end

    task automatic finish_up();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog (all R) actual=hung expected=done");
            finish_up();
        end
    end

    localparam logic [15:0] EDGES [8] = '{16'h007F, 16'h0080, 16'h00FF, 16'h0100,
                                          16'h807F, 16'h8080, 16'h80FF, 16'h8100};

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        // R9: reset state, high half mirrors the low half, window not swapped
        expect_map(16'h8123, "R9");
        expect_map(16'h0080, "R9");
        expect_map(16'h8080, "R9");

        // R7 / R2..R6: every bank and swap setting at the window boundaries
        for (int zp = 0; zp < 2; zp++) begin
            for (int b = 0; b < 4; b++) begin
                cfg_write(2'(b), bit'(zp));
                foreach (EDGES[i]) expect_map(EDGES[i], req_of(EDGES[i], bit'(zp)));
                expect_map(16'h0000, req_of(16'h0000, bit'(zp)));
                expect_map(16'hFFFF, req_of(16'hFFFF, bit'(zp)));
                expect_map(16'h7FFF, req_of(16'h7FFF, bit'(zp)));
            end
        end

        // R7: a write that turns the swap off again (DISABLE_SWAP)
        cfg_write(2'd2, 1'b0);
        expect_map(16'h0090, "R7");
        expect_map(16'h8090, "R7");

        // R8: inputs change without the strobe
        cfg_write(2'd1, 1'b0);
        @(posedge clk); #1;
        cfg_bank = 2'd3; cfg_zp_n = 1'b0;
        expect_map(16'h9000, "R8");
        expect_map(16'h00A0, "R8");
        expect_map(16'h80A0, "R8");

        // R10: strobe patterns with a swapped mapping
        cfg_write(2'd3, 1'b1);
        for (int s = 0; s < 8; s++) begin
            @(posedge clk); #1;
            {cpu_ce_n, cpu_we_n, cpu_oe_n} = 3'(s);
            expect_map(16'h00C0 + 16'(s), "R10");
        end

        // R1 and mixed addresses with the swap on, bank 2
        cfg_write(2'd2, 1'b1);
        for (int k = 0; k < 40; k++) begin
            logic [15:0] a;
            a = 16'(k * 16'h1F3B + 16'h0077);
            expect_map(a, req_of(a, 1'b1));
        end

        // R9: reset from a swapped state
        @(posedge clk); #1 rst = 1'b1;
        @(posedge clk); #1 rst = 1'b0;
        mdl_bank = 2'd0; mdl_zp = 0;
        expect_map(16'h00F0, "R9");
        expect_map(16'hC000, "R9");

        repeat (3) @(posedge clk);
        done = 1;
        finish_up();
    end

endmodule